// File: doc/BRIEF.md
# Snooping Write-Through Data Cache with Posted Store Queue

This block is a direct-mapped data cache for one processor core in a small multiprocessor whose caches share a single memory bus. Loads that find their block resident are answered from a local data array without any bus traffic. Stores always travel to main memory. A store that finds its block resident also refreshes the local copy. Stores are posted into a small first-in, first-out queue, so the core can move on while memory is still busy.

Each cache line holds one data word. The line index is the low part of the word address, which is the address modulo the number of lines. The tag is the remaining upper part. Other caches announce their bus writes on a snoop input. When such a write names a block this cache holds, that line is dropped, and the next local access fetches the fresh value from memory. A load miss is not sent to memory until every posted store has been written. A load therefore never overtakes an older store.

The core side uses a one-cycle request strobe. Requests are taken only while `cpu_stall` is low, and each request is finished by a one-cycle `cpu_done` pulse. The memory side carries one transfer at a time: the request is held until memory returns an acknowledge.

Top module: `snoop_wt_cache`

## Requirements
- R1: A load whose line is valid and whose stored tag equals the upper address bits returns the cached word with `cpu_done` two cycles after acceptance, and it causes no memory read.
- R2: A load miss issues exactly one memory read (`mem_we` = 0). It returns the word supplied by memory, and it installs the line so that a repeated load of that address hits.
- R3: Every store is written to memory with `mem_we` = 1. A store that hits also updates the cached word, so a later load of that address hits and returns the stored value.
- R4: A store miss leaves the cache contents unchanged, so a later load of that address still misses.
- R5: A store accepted while the queue has room completes with `cpu_done` two cycles after acceptance, without waiting for memory.
- R6: A store that finds the queue full keeps the core stalled until an entry has drained, so it takes longer than two cycles.
- R7: Stores reach memory in exactly the order in which the core issued them. A memory request holds its address and direction until it is acknowledged.
- R8: A load miss issues its memory read only after every earlier store has been written to memory.
- R9: A snoop whose address matches a valid resident line clears that line. The next load of that address misses and returns the value now in memory.
- R10: A snoop to an address that is not resident has no effect, including an address that shares an index with a resident block but has a different tag.
- R11: When a snoop to the block being filled arrives in the same cycle as the fill data, the line ends up invalid, and the next load of that address misses.
- R12: After reset, all lines are invalid, `cpu_stall`, `cpu_done` and `mem_req` are low, and the first load of any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle request strobe, taken when `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_stall | output | 1 | High while a request is in progress |
| cpu_done | output | 1 | One-cycle pulse when a request completes |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge that ends the current transfer |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| snoop_valid | input | 1 | Another cache wrote memory in this cycle |
| snoop_addr | input | ADDR_W | Word address of that write |

## Verification
The bench runs a small configuration through sweeps. First it loads every index under two tags, which separates cold misses, repeated hits and evictions. Then it stores to every index, alternating resident and non-resident blocks, which separates hit updates from non-allocating misses. Snoops are sent both to resident blocks and to addresses that share an index but not a tag, which shows whether a line is dropped or kept. A burst of stores against slow memory fills the queue and checks the stall and the write order. A snoop timed to land on the fill cycle shows whether a stale line survives, and counting memory reads at each step separates hits from misses throughout.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FILL  = 2'd3
  } swc_state_e;
endpackage

// File: rtl/swc_tagstore.sv
module swc_tagstore #(
  parameter int LINES = 64,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag
);
  logic             valid_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  assign hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             v_n;
    logic [TAG_W-1:0] t_n;
    // fill first, then a matching snoop on the resulting line clears it
    always_comb begin
      v_n = valid_q[i];
      t_n = tag_q[i];
      if (fill_en && fill_idx == IDX_W'(i)) begin
        v_n = 1'b1;
        t_n = fill_tag;
      end
      if (snp_en && snp_idx == IDX_W'(i) && v_n && t_n == snp_tag)
        v_n = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else begin
        valid_q[i] <= v_n;
        tag_q[i]   <= t_n;
      end
    end
  end

  // R9: a snoop on a resident block with no fill to that line drops it
  a_r9_snoop_drops_line: assert property (@(posedge clk) disable iff (rst)
    (snp_en && valid_q[snp_idx] && tag_q[snp_idx] == snp_tag &&
     !(fill_en && fill_idx == snp_idx))
    |=> !valid_q[$past(snp_idx)]);

  // R11: fill and snoop on the same block in one cycle leave the line invalid
  a_r11_fill_snoop_race: assert property (@(posedge clk) disable iff (rst)
    (fill_en && snp_en && fill_idx == snp_idx && fill_tag == snp_tag)
    |=> !valid_q[$past(fill_idx)]);

  // R2: a fill without a competing snoop installs a valid line
  a_r2_fill_installs: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !(snp_en && snp_idx == fill_idx))
    |=> valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag));
endmodule

// File: rtl/swc_dataram.sv
module swc_dataram #(
  parameter int LINES  = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/swc_wbuf.sv
module swc_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 48,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign head  = slot_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R6: the cache never writes into a full queue
  a_r6_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R7: drain only from a non-empty queue
  a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache
  import swc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int LINES    = 64,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int ENT_W = ADDR_W + DATA_W;

  swc_state_e        state_q;
  logic              rq_we_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;

  logic [IDX_W-1:0]  rq_idx;
  logic [TAG_W-1:0]  rq_tag;
  logic              hit;
  logic              fill_en;
  logic              wb_push, wb_pop, wb_empty, wb_full;
  logic [ENT_W-1:0]  wb_head;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_q;

  assign rq_idx  = rq_addr_q[IDX_W-1:0];
  assign rq_tag  = rq_addr_q[ADDR_W-1:IDX_W];
  assign fill_en = (state_q == ST_FILL) && mem_req && mem_ack && !mem_we;
  assign wb_push = (state_q == ST_LOOK) && rq_we_q && !wb_full;
  assign wb_pop  = mem_req && mem_we && mem_ack;

  assign ram_addr  = (state_q == ST_IDLE) ? cpu_addr[IDX_W-1:0] : rq_idx;
  assign ram_we    = fill_en || (wb_push && hit);
  assign ram_wdata = fill_en ? mem_rdata : rq_wdata_q;

  swc_tagstore #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .look_idx (rq_idx),
    .look_tag (rq_tag),
    .hit      (hit),
    .fill_en  (fill_en),
    .fill_idx (rq_idx),
    .fill_tag (rq_tag),
    .snp_en   (snoop_valid),
    .snp_idx  (snoop_addr[IDX_W-1:0]),
    .snp_tag  (snoop_addr[ADDR_W-1:IDX_W])
  );

  swc_dataram #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );

  swc_wbuf #(.DEPTH(WB_DEPTH), .W(ENT_W)) u_wbuf (
    .clk   (clk),
    .rst   (rst),
    .push  (wb_push),
    .din   ({rq_addr_q, rq_wdata_q}),
    .pop   (wb_pop),
    .head  (wb_head),
    .empty (wb_empty),
    .full  (wb_full)
  );

  // request sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cpu_stall  <= 1'b0;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
      rq_we_q    <= 1'b0;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state_q)
        ST_IDLE: if (cpu_req) begin
          rq_we_q    <= cpu_we;
          rq_addr_q  <= cpu_addr;
          rq_wdata_q <= cpu_wdata;
          cpu_stall  <= 1'b1;
          state_q    <= ST_LOOK;
        end
        ST_LOOK: begin
          if (rq_we_q) begin
            if (!wb_full) begin
              cpu_done  <= 1'b1;
              cpu_stall <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end else if (hit) begin
            cpu_rdata <= ram_q;
            cpu_done  <= 1'b1;
            cpu_stall <= 1'b0;
            state_q   <= ST_IDLE;
          end else begin
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (!mem_req && wb_empty) state_q <= ST_FILL;
        ST_FILL: if (fill_en) begin
          cpu_rdata <= mem_rdata;
          cpu_done  <= 1'b1;
          cpu_stall <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // memory port: queued stores first, a fill only once the queue is empty
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (!wb_empty) begin
      mem_req   <= 1'b1;
      mem_we    <= 1'b1;
      mem_addr  <= wb_head[ENT_W-1:DATA_W];
      mem_wdata <= wb_head[DATA_W-1:0];
    end else if (state_q == ST_DRAIN) begin
      mem_req  <= 1'b1;
      mem_we   <= 1'b0;
      mem_addr <= rq_addr_q;
    end
  end

  // R8: a memory read is only ever issued with the store queue empty
  a_r8_read_after_drain: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> wb_empty);
  // R7: a pending memory transfer keeps its address and direction
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R5: completion is a single-cycle pulse that also releases the stall
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_stall ##1 !cpu_done);
  // R1: a load that hits completes without touching the memory port
  a_r1_hit_no_bus: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && !rq_we_q && hit) |=> cpu_done);
endmodule

// File: tb/sim_snoop_wt_cache.sv
module sim_snoop_wt_cache;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 8;
  localparam int WBD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_stall, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic snoop_valid;
  logic [AW-1:0] snoop_addr;

  logic t_snp = 1'b0, c_snp = 1'b0;
  logic [AW-1:0] t_sa = '0, c_sa = '0;
  assign snoop_valid = t_snp | c_snp;
  assign snoop_addr  = c_snp ? c_sa : t_sa;

  always #4 clk = ~clk;

  snoop_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WB_DEPTH(WBD)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr));

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] mm [256];
  logic [DW-1:0] sh [256];
  logic [AW-1:0] ex_a [64];
  logic [DW-1:0] ex_d [64];
  int n_ex = 0, n_log = 0, rd_cnt = 0, lat = 2, mcnt = 0;
  logic c_arm = 1'b0;
  logic [AW-1:0] c_a = '0;
  logic [DW-1:0] c_d = '0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // simple memory with fixed latency, acting at the falling edge
  always @(negedge clk) begin
    c_snp <= 1'b0;
    if (mem_ack) begin
      mem_ack <= 1'b0;
      mcnt = 0;
    end else if (mem_req && !rst) begin
      mcnt++;
      if (mcnt >= lat) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          chk(n_log < n_ex && ex_a[n_log] == mem_addr, "R7 write address order",
              mem_addr, ex_a[n_log]);
          chk(ex_d[n_log] == mem_wdata, "R3 write-through data", mem_wdata, ex_d[n_log]);
          mm[mem_addr] = mem_wdata;
          n_log++;
        end else begin
          chk(n_log == n_ex, "R8 read before stores drained", n_log, n_ex);
          mem_rdata <= mm[mem_addr];
          rd_cnt++;
          if (c_arm && mem_addr == c_a) begin
            c_snp <= 1'b1;
            c_sa  <= c_a;
            mm[c_a] = c_d;
            sh[c_a] = c_d;
            c_arm = 1'b0;
          end
        end
      end
    end
  end

  task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    output logic [DW-1:0] q, output int cyc);
    @(negedge clk);
    while (cpu_stall) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    cyc = 1;
    while (!cpu_done) begin
      @(negedge clk);
      cyc++;
    end
    q = cpu_rdata;
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit miss, input string rq);
    logic [DW-1:0] q;
    int c, r0;
    logic [DW-1:0] e;
    e = sh[a];
    r0 = rd_cnt;
    op(1'b0, a, '0, q, c);
    chk(q == e, {rq, " load value"}, q, e);
    chk((rd_cnt - r0) == (miss ? 1 : 0), {rq, " memory reads"}, rd_cnt - r0, miss ? 1 : 0);
    if (!miss) chk(c == 2, {rq, " hit latency"}, c, 2);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int c);
    logic [DW-1:0] q;
    ex_a[n_ex] = a; ex_d[n_ex] = d; n_ex++;
    sh[a] = d;
    op(1'b1, a, d, q, c);
  endtask

  task automatic other_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    mm[a] = d; sh[a] = d;
    t_snp = 1'b1; t_sa = a;
    @(negedge clk);
    t_snp = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c;
    for (int i = 0; i < 256; i++) begin
      mm[i] = DW'(i * 37 + 5);
      sh[i] = mm[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cpu_stall && !cpu_done && !mem_req, "R12 reset outputs",
        {cpu_stall, cpu_done, mem_req}, 0);

    // R12/R2: cold misses over every index, then R1 hits
    for (int a = 0; a < NL; a++) rd(AW'(a), 1'b1, "R12 cold miss");
    for (int a = 0; a < NL; a++) rd(AW'(a), 1'b0, "R1 hit");
    // R2: second tag evicts, then first tag misses again
    for (int a = NL; a < 2 * NL; a++) rd(AW'(a), 1'b1, "R2 conflict miss");
    for (int a = NL; a < 2 * NL; a++) rd(AW'(a), 1'b0, "R2 refill hit");

    // R3 store hits on resident blocks, R4 store misses on the other tag
    for (int a = NL; a < 2 * NL; a++) begin
      wr(AW'(a), DW'(16'hA000 + a), c);
      chk(c == 2, "R5 posted store latency", c, 2);
      wr(AW'(a - NL), DW'(16'hB000 + a), c);
    end
    for (int a = NL; a < 2 * NL; a++) rd(AW'(a), 1'b0, "R3 updated hit");
    for (int a = 0; a < NL; a++) rd(AW'(a), 1'b1, "R4 no allocate");
    for (int a = NL; a < 2 * NL; a++) rd(AW'(a), 1'b1, "R8 refill after stores");

    // R10: snoops to same index, other tag, and unrelated addresses
    for (int a = 0; a < NL; a++) other_write(AW'(a + 2 * NL), DW'(16'hC000 + a));
    for (int a = 0; a < NL; a++) other_write(AW'(a), DW'(16'hC100 + a));
    for (int a = NL; a < 2 * NL; a++) rd(AW'(a), 1'b0, "R10 snoop ignored");

    // R9: snoop on resident blocks drops them
    for (int a = NL; a < 2 * NL; a += 2) other_write(AW'(a), DW'(16'hD000 + a));
    for (int a = NL; a < 2 * NL; a++) rd(AW'(a), (a % 2) == 0, "R9 snoop invalidate");

    // R6/R7: burst of stores against slow memory
    lat = 20;
    for (int k = 0; k < WBD + 2; k++) begin
      wr(AW'(40 + k), DW'(16'hE000 + k), c);
      if (k < WBD) chk(c == 2, "R5 store posted into queue", c, 2);
      else chk(c > 2, "R6 stall on full queue", c, 3);
    end
    rd(AW'(40 + WBD), 1'b1, "R8 load behind burst");
    lat = 2;

    // R11: snoop lands in the same cycle as the fill data
    begin
      logic [DW-1:0] q;
      logic [DW-1:0] old;
      int r0;
      old = sh[50];
      c_a = AW'(50); c_d = 16'h5A5A; c_arm = 1'b1;
      r0 = rd_cnt;
      op(1'b0, AW'(50), '0, q, c);
      chk(q == old, "R11 fill returns memory value", q, old);
      chk(rd_cnt - r0 == 1, "R11 fill read", rd_cnt - r0, 1);
      rd(AW'(50), 1'b1, "R11 line invalid after race");
      rd(AW'(50), 1'b0, "R11 refetched line hits");
    end

    // final drain: memory matches program order result
    while (n_log != n_ex || mem_req) @(negedge clk);
    for (int i = 0; i < 64; i++)
      chk(mm[i] == sh[i], "R3 memory image", mm[i], sh[i]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule